// File: doc/BRIEF.md
# Two-Level Virtual Page Translator

This block turns an 18-bit virtual address into a 20-bit physical address. A request is first looked up in a small direct-mapped translation buffer. When the buffer misses, a full page table with one slot per virtual page is read. When the page table also has no valid slot, the block asks an external agent to bring the page in and waits for the physical page number it returns.

The upper nine bits of the virtual address select the virtual page. The lower nine bits are the byte offset inside the page, and they pass through to the physical address unchanged. Every result carries a two-bit code that says which structure supplied the page number. Pages that have been loaded stay in the page table until reset. Only one translation is in flight at a time, so a requester simply waits for `req_ready` before presenting the next address.

Top module: `vpage_xlate`

## Requirements
- R1: `resp_paddr` is the 11-bit physical page number in bits [19:9], followed by the request's offset `req_vaddr[8:0]` in bits [8:0].
- R2: The buffer is direct-mapped with 16 slots. It is indexed by `req_vaddr[12:9]` (the low four VPN bits) and tagged with `req_vaddr[17:13]`. A hit gives `resp_src` = 1 with `resp_valid` one cycle after the request is accepted.
- R3: After reset every buffer slot and every page-table slot is invalid, so the first translation of any page goes to the fault path.
- R4: A buffer miss with a valid page-table slot gives `resp_src` = 2 two cycles after acceptance. It also overwrites the buffer slot at that index, so the same page then hits in the buffer.
- R5: On a page-table miss, `load_req_valid` rises with `load_req_vpn` equal to the request's VPN. Both stay stable until a cycle in which `load_resp_valid` is high.
- R6: `load_resp_ppn` is sampled in the cycle `load_resp_valid` is high. The response follows one cycle later with `resp_src` = 3 and that page number. The number is written into both the page table and the buffer.
- R7: A page-table slot, once written, is never cleared. A page pushed out of the buffer by a conflicting page is later found in the page table.
- R8: `req_ready` is high only when no translation is in progress. It is low from the cycle after a miss is accepted up to the response cycle.
- R9: Each accepted request produces exactly one `resp_valid` pulse of one cycle. No pulse occurs without an accepted request. `resp_src` is 0 when `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is presented |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vaddr | input | 18 | Virtual address: VPN [17:9], offset [8:0] |
| resp_valid | output | 1 | One-cycle pulse with the result |
| resp_paddr | output | 20 | Physical address: PPN [19:9], offset [8:0] |
| resp_src | output | 2 | Source of the PPN: 1 buffer, 2 page table, 3 fault load |
| load_req_valid | output | 1 | Frame load requested for a missing page |
| load_req_vpn | output | 9 | Page whose frame is requested |
| load_resp_valid | input | 1 | Frame load finished this cycle |
| load_resp_ppn | input | 11 | Physical page number of the loaded frame |

## Verification
Several properties are checked on every cycle:
- the latency of each source relative to acceptance;
- that the offset is carried through on a buffer hit;
- that the load request holds steady while it waits;
- that `req_ready` is low during a fault;
- that no valid page-table bit ever drops.

Other behaviour can only be shown by the bench's scenarios, which run against a behavioural model of both structures:
- that an eviction by a conflicting tag sends the next access to the page table;
- that a fill makes the following access hit in the buffer;
- that the correct loaded number reaches `resp_paddr`.

// File: rtl/vpage_xlate_pkg.sv
package vpage_xlate_pkg;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_TLB   = 2'd1,
        SRC_PTAB  = 2'd2,
        SRC_FAULT = 2'd3
    } ppn_src_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PTLOOK = 2'd1,
        ST_FAULT  = 2'd2
    } xlate_st_e;

endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
    parameter int VPN_W = 9,
    parameter int PPN_W = 11,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn
);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    tlb_ent_t         slot_vec [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    tlb_ent_t         lk_ent;

    assign wr_idx = wr_vpn[IDX_W-1:0];
    assign wr_tag = wr_vpn[VPN_W-1:IDX_W];
    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        tlb_ent_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                slot_d.valid = 1'b1;
                slot_d.tag   = wr_tag;
                slot_d.ppn   = wr_ppn;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign slot_vec[i] = slot_q;
    end

    assign lk_ent = slot_vec[lk_idx];
    assign lk_hit = lk_ent.valid && (lk_ent.tag == lk_tag);
    assign lk_ppn = lk_ent.ppn;

    // R4: a slot just filled answers a lookup of the same page on the next cycle
    assert_fill_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) == 1'b0 && lk_vpn == wr_vpn) |=> (lk_vpn != $past(wr_vpn)) || lk_hit);

endmodule

// File: rtl/xlate_ptab.sv
module xlate_ptab #(
    parameter int VPN_W = 9,
    parameter int PPN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic             rd_valid,
    output logic [PPN_W-1:0] rd_ppn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn
);
    localparam int DEPTH = 1 << VPN_W;

    logic [DEPTH-1:0] valid_vec;
    logic [PPN_W-1:0] ppn_vec [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_pte
        logic             v_d, v_q;
        logic [PPN_W-1:0] p_d, p_q;

        always_comb begin
            v_d = v_q;
            p_d = p_q;
            if (wr_en && (wr_vpn == VPN_W'(i))) begin
                v_d = 1'b1;
                p_d = wr_ppn;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                p_q <= '0;
            end else begin
                v_q <= v_d;
                p_q <= p_d;
            end
        end

        assign valid_vec[i] = v_q;
        assign ppn_vec[i]   = p_q;
    end

    assign rd_valid = valid_vec[rd_vpn];
    assign rd_ppn   = ppn_vec[rd_vpn];

    // R7: once a page is present it stays present
    assert_never_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec & $past(valid_vec)) == $past(valid_vec));

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import vpage_xlate_pkg::*;
#(
    parameter int VPN_W = 9,
    parameter int OFF_W = 9,
    parameter int PPN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    output logic             resp_valid,
    output logic [PPN_W+OFF_W-1:0] resp_paddr,
    output logic [1:0]       resp_src,
    output logic             load_req_valid,
    output logic [VPN_W-1:0] load_req_vpn,
    input  logic             load_resp_valid,
    input  logic [PPN_W-1:0] load_resp_ppn,
    output logic [VPN_W-1:0] tlb_lk_vpn,
    input  logic             tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    output logic             tlb_wr,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PPN_W-1:0] fill_ppn,
    output logic [VPN_W-1:0] pt_rd_vpn,
    input  logic             pt_valid,
    input  logic [PPN_W-1:0] pt_ppn,
    output logic             pt_wr
);
    localparam int VA_W = VPN_W + OFF_W;
    localparam int PA_W = PPN_W + OFF_W;

    typedef struct packed {
        xlate_st_e       st;
        logic [VA_W-1:0] va;
        logic            rv;
        logic [PA_W-1:0] pa;
        ppn_src_e        src;
        logic            lrv;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [OFF_W-1:0] held_off;
    logic [VPN_W-1:0] held_vpn;

    assign held_off = ctl_q.va[OFF_W-1:0];
    assign held_vpn = ctl_q.va[VA_W-1:OFF_W];

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rv  = 1'b0;
        ctl_d.src = SRC_NONE;
        tlb_wr    = 1'b0;
        pt_wr     = 1'b0;
        fill_ppn  = pt_ppn;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.va = req_vaddr;
                    if (tlb_hit) begin
                        ctl_d.rv  = 1'b1;
                        ctl_d.pa  = {tlb_ppn, req_vaddr[OFF_W-1:0]};
                        ctl_d.src = SRC_TLB;
                    end else begin
                        ctl_d.st = ST_PTLOOK;
                    end
                end
            end
            ST_PTLOOK: begin
                if (pt_valid) begin
                    tlb_wr    = 1'b1;
                    fill_ppn  = pt_ppn;
                    ctl_d.rv  = 1'b1;
                    ctl_d.pa  = {pt_ppn, held_off};
                    ctl_d.src = SRC_PTAB;
                    ctl_d.st  = ST_IDLE;
                end else begin
                    ctl_d.lrv = 1'b1;
                    ctl_d.st  = ST_FAULT;
                end
            end
            ST_FAULT: begin
                if (load_resp_valid) begin
                    tlb_wr    = 1'b1;
                    pt_wr     = 1'b1;
                    fill_ppn  = load_resp_ppn;
                    ctl_d.rv  = 1'b1;
                    ctl_d.pa  = {load_resp_ppn, held_off};
                    ctl_d.src = SRC_FAULT;
                    ctl_d.lrv = 1'b0;
                    ctl_d.st  = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.lrv = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= ST_IDLE;
            ctl_q.src <= SRC_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready      = (ctl_q.st == ST_IDLE);
    assign resp_valid     = ctl_q.rv;
    assign resp_paddr     = ctl_q.pa;
    assign resp_src       = ctl_q.src;
    assign load_req_valid = ctl_q.lrv;
    assign load_req_vpn   = held_vpn;
    assign tlb_lk_vpn     = req_vaddr[VA_W-1:OFF_W];
    assign fill_vpn       = held_vpn;
    assign pt_rd_vpn      = held_vpn;

    // R1: the page offset of a buffer hit is the one that was requested
    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_src == SRC_TLB) |-> resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

    // R2: buffer hit answers one cycle after acceptance
    assert_tlb_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_src == SRC_TLB) |-> $past(req_valid && req_ready));

    // R4: page-table hit answers two cycles after acceptance
    assert_ptab_two_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_src == SRC_PTAB) |-> $past(req_valid && req_ready, 2));

    // R5: the load request holds until it is answered
    assert_load_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req_valid && !load_resp_valid) |=> (load_req_valid && $stable(load_req_vpn)));

    // R6: a fault result follows the load response by one cycle
    assert_fault_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_src == SRC_FAULT) |-> $past(load_req_valid && load_resp_valid));

    // R8: no new request is accepted while a frame load is pending
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_valid |-> !req_ready);

    // R9: a second consecutive pulse needs a fresh acceptance; idle code is zero
    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid || $past(req_valid && req_ready)));
    assert_src_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> resp_src == SRC_NONE);

endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
    parameter int VPN_W     = 9,
    parameter int OFF_W     = 9,
    parameter int PPN_W     = 11,
    parameter int TLB_IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    output logic                   resp_valid,
    output logic [PPN_W+OFF_W-1:0] resp_paddr,
    output logic [1:0]             resp_src,
    output logic                   load_req_valid,
    output logic [VPN_W-1:0]       load_req_vpn,
    input  logic                   load_resp_valid,
    input  logic [PPN_W-1:0]       load_resp_ppn
);
    logic [VPN_W-1:0] tlb_lk_vpn;
    logic             tlb_hit;
    logic [PPN_W-1:0] tlb_ppn;
    logic             tlb_wr;
    logic [VPN_W-1:0] fill_vpn;
    logic [PPN_W-1:0] fill_ppn;
    logic [VPN_W-1:0] pt_rd_vpn;
    logic             pt_valid;
    logic [PPN_W-1:0] pt_ppn;
    logic             pt_wr;

    xlate_ctrl #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_src(resp_src),
        .load_req_valid(load_req_valid), .load_req_vpn(load_req_vpn),
        .load_resp_valid(load_resp_valid), .load_resp_ppn(load_resp_ppn),
        .tlb_lk_vpn(tlb_lk_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .tlb_wr(tlb_wr), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .pt_rd_vpn(pt_rd_vpn), .pt_valid(pt_valid), .pt_ppn(pt_ppn), .pt_wr(pt_wr)
    );

    xlate_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(TLB_IDX_W)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(tlb_lk_vpn), .lk_hit(tlb_hit), .lk_ppn(tlb_ppn),
        .wr_en(tlb_wr), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn)
    );

    xlate_ptab #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ptab (
        .clk(clk), .rst_n(rst_n),
        .rd_vpn(pt_rd_vpn), .rd_valid(pt_valid), .rd_ppn(pt_ppn),
        .wr_en(pt_wr), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn)
    );

endmodule

// File: tb/vpage_xlate_tb.sv
`timescale 1ns/1ps
module vpage_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [17:0] req_vaddr;
    logic        resp_valid;
    logic [19:0] resp_paddr;
    logic [1:0]  resp_src;
    logic        load_req_valid;
    logic [8:0]  load_req_vpn;
    logic        load_resp_valid;
    logic [10:0] load_resp_ppn;

    always #2.5 clk = ~clk;

    vpage_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_src(resp_src),
        .load_req_valid(load_req_valid), .load_req_vpn(load_req_vpn),
        .load_resp_valid(load_resp_valid), .load_resp_ppn(load_resp_ppn)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // behavioural model of both structures
    bit m_tlb_v   [16];
    int m_tlb_tag [16];
    int m_tlb_ppn [16];
    bit m_pt_v    [int];
    int m_pt_ppn  [int];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int frame_for(int vpn, int salt);
        return (vpn * 37 + salt * 101 + 5) & 'h7FF;
    endfunction

    task automatic xlate(input int vpn, input int off, input int delay,
                         input int salt, input string tag);
        int idx = vpn & 15;
        int vtag = vpn >> 4;
        int exp_src, exp_lat, exp_ppn, cyc, waited, lr;
        bit done;
        if (m_tlb_v[idx] && m_tlb_tag[idx] == vtag) begin
            exp_src = 1; exp_lat = 1; exp_ppn = m_tlb_ppn[idx];
        end else if (m_pt_v.exists(vpn)) begin
            exp_src = 2; exp_lat = 2; exp_ppn = m_pt_ppn[vpn];
        end else begin
            exp_src = 3; exp_lat = -1; exp_ppn = frame_for(vpn, salt);
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9", "no pulse between requests", int'(resp_valid), 0);
        chk(req_ready == 1'b1, "R8", "ready when idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_vaddr = 18'((vpn << 9) | off);
        cyc = 0; waited = 0; lr = -1; done = 0;
        while (!done && cyc < 80) begin
            @(negedge clk);
            cyc++;
            req_valid = 1'b0;
            load_resp_valid = 1'b0;
            if (resp_valid) begin
                if (exp_src == 3) exp_lat = lr + 1;
                chk(int'(resp_src) == exp_src, tag, "source code", int'(resp_src), exp_src);
                chk(cyc == exp_lat, tag, "latency", cyc, exp_lat);
                chk(int'(resp_paddr) == ((exp_ppn << 9) | off), "R1", "physical address",
                    int'(resp_paddr), (exp_ppn << 9) | off);
                done = 1;
            end else begin
                chk(req_ready == 1'b0, "R8", "busy not ready", int'(req_ready), 0);
                if (load_req_valid) begin
                    chk(exp_src == 3, "R5", "load only on page-table miss", exp_src, 3);
                    chk(int'(load_req_vpn) == vpn, "R5", "load vpn held", int'(load_req_vpn), vpn);
                    waited++;
                    if (waited > delay) begin
                        load_resp_valid = 1'b1;
                        load_resp_ppn   = 11'(frame_for(vpn, salt));
                        lr = cyc;
                    end
                end
            end
        end
        if (!done) chk(1'b0, "R9", "response missing", 0, 1);
        if (exp_src == 3) begin
            m_pt_v[vpn] = 1'b1;
            m_pt_ppn[vpn] = exp_ppn;
        end
        m_tlb_v[idx] = 1'b1;
        m_tlb_tag[idx] = vtag;
        m_tlb_ppn[idx] = exp_ppn;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        load_resp_valid = 1'b0;
        load_resp_ppn = '0;
        repeat (4) @(negedge clk);
        chk(resp_valid == 1'b0, "R9", "reset resp_valid", int'(resp_valid), 0);
        chk(load_req_valid == 1'b0, "R3", "reset load_req_valid", int'(load_req_valid), 0);
        chk(resp_src == 2'd0, "R9", "reset source", int'(resp_src), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready after reset", int'(req_ready), 1);

        // R3/R6: first touch of a page faults and fills
        xlate(9'h025, 9'h1A3, 0, 1, "R3");
        // R2: same page hits the buffer
        xlate(9'h025, 9'h000, 0, 1, "R2");
        // R6: conflicting page (same index 5), slow loader
        xlate(9'h035, 9'h1FF, 7, 2, "R6");
        // R7: evicted page still in the page table; R4 refills the buffer
        xlate(9'h025, 9'h0FF, 0, 1, "R7");
        xlate(9'h025, 9'h055, 0, 1, "R4");
        xlate(9'h035, 9'h001, 0, 2, "R7");
        // boundary pages
        xlate(9'h000, 9'h000, 2, 3, "R3");
        xlate(9'h1FF, 9'h1FF, 1, 4, "R6");
        xlate(9'h000, 9'h1FF, 0, 3, "R2");
        xlate(9'h1FF, 9'h000, 0, 4, "R2");
        // fill every slot with tag 3, then hit them all
        for (int i = 0; i < 16; i++) xlate(i | (3 << 4), i * 31, i % 3, 5, "R6");
        for (int i = 0; i < 16; i++) xlate(i | (3 << 4), 511 - i, 0, 5, "R2");
        // overwrite with tag 9, then go back to tag 3 through the page table
        for (int i = 0; i < 16; i++) xlate(i | (9 << 4), i, 0, 6, "R6");
        for (int i = 0; i < 16; i++) xlate(i | (3 << 4), i * 7, 0, 5, "R4");
        for (int i = 0; i < 16; i++) xlate(i | (3 << 4), i * 5, 0, 5, "R2");

        repeat (2) @(negedge clk);
        chk(resp_valid == 1'b0, "R9", "quiet after last request", int'(resp_valid), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule